// File: doc/BRIEF.md
# Strobed Input Interrupt Handshake

This block generates an interrupt request for a strobed parallel input. An external device pulls an active-low input strobe to say that it has presented data. The host answers by pulsing an active-low read strobe. The block raises its interrupt request once the input strobe has been seen, and drops it again when the host reads. A second output copies the interrupt flag so that the surrounding status word can carry it. Neighbouring logic places that copy at bit 2 of the status word.

Both pins are asynchronous to the system clock. Each one passes through a two-flop synchronizer before any decision uses it, and neither pin ever clocks or resets a flop. After synchronization, the input strobe goes through a runt filter that needs two consecutive low samples. An active read has priority over a set, so a set and a clear can never race. One consequence is accepted: a strobe that starts and ends entirely inside a read is lost.

Top module: `strb_hs_top`

## Requirements
- R1: If stb_n_i is sampled low at rising edges k and k+1, and rd_n_i is sampled high at edge k+1, then irq_o is 1 after edge k+3. This is at most four clock cycles after the pin falls.
- R2: A low level on stb_n_i that is seen at only one rising edge, with a high sample on each side, never sets irq_o.
- R3: If rd_n_i is sampled low at rising edge k, then irq_o is 0 after edge k+2.
- R4: A read has priority. If rd_n_i is sampled low at edge k+1, a strobe sampled low at edges k and k+1 does not set irq_o after edge k+3.
- R5: When neither R1 nor R3 applies at an edge, irq_o keeps its previous value.
- R6: status_bit_o equals irq_o in every cycle.
- R7: While rst_n is sampled low at a rising edge, irq_o and status_bit_o become 0. Any pin samples taken during reset count as high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| stb_n_i | input | 1 | Asynchronous input strobe, active low |
| rd_n_i | input | 1 | Asynchronous host read strobe, active low |
| irq_o | output | 1 | Interrupt request, active high |
| status_bit_o | output | 1 | Copy of the interrupt flag for the status word |

## Verification
The pin-level properties assume that each pin holds its level for whole clock periods. They reason from the value captured at each rising edge and ignore sub-cycle glitches, which the synchronizer would in any case resolve to one level or the other. The stimulus drives both pins only on falling clock edges, so every level is a clean whole-cycle sample. With that stimulus, a single-cycle low pulse is the shortest possible runt. Reset is applied from time zero with the strobe already low, so the history that the properties look back on is always defined.

// File: rtl/strb_hs_pkg.sv
// Shared types for the strobed input handshake.
// Assumes: nothing beyond a single system clock domain.
package strb_hs_pkg;
    // Decision the flag register takes at each edge
    typedef enum logic [1:0] {
        FLAG_HOLD  = 2'd0,
        FLAG_SET   = 2'd1,
        FLAG_CLEAR = 2'd2
    } flag_act_e;
endpackage

// File: rtl/strb_hs_sync.sv
// Multi-flop synchronizer for one asynchronous active-low pin.
// Assumes STAGES >= 2; reset loads the inactive (high) level into every stage.
module strb_hs_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    output logic sync_o
);
    logic [STAGES-1:0] stage_q;

    // Shift the pin level through the synchronizer chain
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            stage_q <= '1;
        end else begin
            stage_q <= {stage_q[STAGES-2:0], pin_i};
        end
    end

    assign sync_o = stage_q[STAGES-1];
endmodule

// File: rtl/strb_hs_filter.sv
// Runt filter: reports a valid strobe once the synchronized active-low
// level has been low for DEPTH consecutive samples.
// Assumes DEPTH >= 2 and that the input is already synchronized.
module strb_hs_filter #(
    parameter int DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic lvl_n_i,
    output logic valid_o
);
    localparam int HIST = DEPTH - 1;

    logic [HIST-1:0] hist_q;

    // Keep the previous HIST synchronized samples, newest in bit 0
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hist_q <= '1;
        end else begin
            hist_q[0] <= lvl_n_i;
            for (int i = 1; i < HIST; i++) begin
                hist_q[i] <= hist_q[i-1];
            end
        end
    end

    // Valid only when the current sample and all held ones are low
    always_comb begin
        valid_o = !lvl_n_i && (hist_q == '0);
    end
endmodule

// File: rtl/strb_hs_flag.sv
// Interrupt flag register with read priority over set.
// Assumes rd_act_i and stb_ok_i are already synchronous to clk.
module strb_hs_flag
    import strb_hs_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic rd_act_i,
    input  logic stb_ok_i,
    output logic flag_o
);
    flag_act_e act;

    // Choose the action: a read clears and blocks any set
    always_comb begin
        if (rd_act_i) begin
            act = FLAG_CLEAR;
        end else if (stb_ok_i) begin
            act = FLAG_SET;
        end else begin
            act = FLAG_HOLD;
        end
    end

    // Apply the chosen action to the flag
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_o <= 1'b0;
        end else begin
            case (act)
                FLAG_SET:   flag_o <= 1'b1;
                FLAG_CLEAR: flag_o <= 1'b0;
                default:    flag_o <= flag_o;
            endcase
        end
    end

    // R3
    rd_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rd_act_i |=> !flag_o);

    // R5
    idle_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_act_i && !stb_ok_i) |=> $stable(flag_o));
endmodule

// File: rtl/strb_hs_top.sv
// Strobed input interrupt handshake: synchronizes both pins, filters
// the input strobe, and sets/clears the interrupt flag.
// Assumes both pins are asynchronous, active low and idle high.
module strb_hs_top #(
    parameter int SYNC_STAGES  = 2,
    parameter int FILTER_DEPTH = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic stb_n_i,
    input  logic rd_n_i,
    output logic irq_o,
    output logic status_bit_o
);
    logic stb_sync_n;
    logic rd_sync_n;
    logic stb_ok;
    logic rd_act;
    logic flag;

    strb_hs_sync #(.STAGES(SYNC_STAGES)) u_stb_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(stb_n_i), .sync_o(stb_sync_n)
    );

    strb_hs_sync #(.STAGES(SYNC_STAGES)) u_rd_sync (
        .clk(clk), .rst_n(rst_n), .pin_i(rd_n_i), .sync_o(rd_sync_n)
    );

    strb_hs_filter #(.DEPTH(FILTER_DEPTH)) u_filter (
        .clk(clk), .rst_n(rst_n), .lvl_n_i(stb_sync_n), .valid_o(stb_ok)
    );

    assign rd_act = !rd_sync_n;

    strb_hs_flag u_flag (
        .clk(clk), .rst_n(rst_n), .rd_act_i(rd_act),
        .stb_ok_i(stb_ok), .flag_o(flag)
    );

    assign irq_o        = flag;
    assign status_bit_o = flag;

    // R1 R4 (pin history with default stage counts)
    set_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(irq_o) && $past(rst_n)) |->
            (!$past(stb_n_i, 3) && !$past(stb_n_i, 4) && $past(rd_n_i, 3)));

    // R3
    clear_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(irq_o) && $past(rst_n)) |-> !$past(rd_n_i, 3));

    // R7
    reset_clear_chk: assert property (@(posedge clk)
        !rst_n |=> (!irq_o && !status_bit_o));
endmodule

// File: tb/tb_strb_hs_top.sv
module tb_strb_hs_top;
    localparam int CLK_PERIOD = 10;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic stb_n = 1'b0;
    logic rd_n = 1'b1;
    logic irq, status;

    int vectors = 0;
    int miscompares = 0;
    bit exp_irq = 1'b0;
    bit last_irq = 1'b0;
    bit hs [4];
    bit hr [4];
    string tag = "R7";

    strb_hs_top dut (
        .clk(clk), .rst_n(rst_n), .stb_n_i(stb_n), .rd_n_i(rd_n),
        .irq_o(irq), .status_bit_o(status)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model: history of pin samples, newest at index 0
    always @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < 4; i++) begin hs[i] = 1'b1; hr[i] = 1'b1; end
            exp_irq = 1'b0;
        end else begin
            for (int i = 3; i > 0; i--) begin hs[i] = hs[i-1]; hr[i] = hr[i-1]; end
            hs[0] = stb_n;
            hr[0] = rd_n;
            if (!hr[2]) exp_irq = 1'b0;
            else if (!hs[2] && !hs[3]) exp_irq = 1'b1;
        end
    end

    task automatic cyc(input logic s, input logic r);
        @(negedge clk);
        vectors++;
        if (irq !== exp_irq) begin
            miscompares++;
            $display("FAIL %s irq actual=%b expected=%b t=%0t", tag, irq, exp_irq, $time);
        end
        vectors++;
        if (status !== exp_irq) begin
            miscompares++;
            $display("FAIL R6 status actual=%b expected=%b t=%0t", status, exp_irq, $time);
        end
        last_irq = irq;
        stb_n = s;
        rd_n = r;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) cyc(1'b1, 1'b1);
    endtask

    task automatic direct(input string req, input bit expv);
        vectors++;
        if (last_irq !== expv) begin
            miscompares++;
            $display("FAIL %s directed actual=%b expected=%b t=%0t", req, last_irq, expv, $time);
        end
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        miscompares++;
        $display("FAIL watchdog expired");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        // R7: reset with strobe already low; reset samples count as high
        tag = "R7";
        for (int i = 0; i < 3; i++) cyc(1'b0, 1'b1);
        direct("R7", 1'b0);
        @(negedge clk); rst_n = 1'b1; stb_n = 1'b0;
        cyc(1'b0, 1'b1); cyc(1'b0, 1'b1); cyc(1'b1, 1'b1);
        direct("R7", 1'b0);
        cyc(1'b1, 1'b1);
        direct("R7", 1'b1);
        // R3: one-cycle read clears two edges later
        tag = "R3";
        cyc(1'b1, 1'b0); cyc(1'b1, 1'b1); cyc(1'b1, 1'b1);
        direct("R3", 1'b1);
        cyc(1'b1, 1'b1);
        direct("R3", 1'b0);
        idle(4);
        // R2: runt strobe rejected
        tag = "R2";
        cyc(1'b0, 1'b1);
        idle(8);
        direct("R2", 1'b0);
        // R1: two-cycle strobe sets on the fourth edge
        tag = "R1";
        cyc(1'b0, 1'b1); cyc(1'b0, 1'b1); cyc(1'b1, 1'b1); cyc(1'b1, 1'b1);
        direct("R1", 1'b0);
        cyc(1'b1, 1'b1);
        direct("R1", 1'b1);
        // R5: hold while idle; second strobe keeps it set
        tag = "R5";
        idle(10);
        direct("R5", 1'b1);
        cyc(1'b0, 1'b1); cyc(1'b0, 1'b1);
        idle(5);
        direct("R5", 1'b1);
        // R4: strobe wholly inside a long read is lost
        tag = "R4";
        cyc(1'b1, 1'b0); cyc(1'b1, 1'b0);
        cyc(1'b0, 1'b0); cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
        cyc(1'b1, 1'b0); cyc(1'b1, 1'b0);
        idle(8);
        direct("R4", 1'b0);
        // R4: strobe held across read end sets once read is gone
        cyc(1'b1, 1'b0); cyc(1'b0, 1'b0); cyc(1'b0, 1'b0);
        cyc(1'b0, 1'b1); cyc(1'b0, 1'b1); cyc(1'b1, 1'b1);
        idle(6);
        direct("R4", 1'b1);
        // R1: longer strobe, then read and strobe alternate
        tag = "R1";
        cyc(1'b1, 1'b0);
        idle(5);
        for (int k = 0; k < 6; k++) begin
            cyc(1'b0, 1'b1); cyc(1'b0, 1'b1); cyc(1'b0, 1'b1);
            idle(3);
            cyc(1'b1, 1'b0);
            idle(3);
        end
        direct("R3", 1'b0);
        // R7: reset mid-operation clears a set flag
        tag = "R7";
        cyc(1'b0, 1'b1); cyc(1'b0, 1'b1);
        idle(5);
        direct("R7", 1'b1);
        @(negedge clk); rst_n = 1'b0;
        cyc(1'b1, 1'b1); cyc(1'b1, 1'b1);
        direct("R7", 1'b0);
        @(negedge clk); rst_n = 1'b1;
        idle(4);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule